// File: doc/BRIEF.md
# Four-Channel Priority DMA Engine

The block moves data between memory locations without processor involvement. Four channels each hold a source address, a destination address, an element count and a control word, all written over a simple register port. When a channel becomes pending, the engine takes the memory bus. For each element it reads from the source, writes to the destination, then steps both addresses by the mode given in the channel's control word. A run continues until the count is used up.

A channel starts at once when it is enabled, or waits for a rising edge on its own trigger input. When several channels are pending, a fixed-priority arbiter picks the lowest-numbered one. A run always finishes before the next one starts. The CPU is stalled for the whole run, and done interrupts are held back until the engine is idle again. Each channel has its own address-region permissions. An element that would break them is dropped and recorded in a sticky error bit.

Top module: `quad_dma`

## Requirements
- R1: When more than one channel is pending, the channel with the lowest number runs first. A started run completes before any other channel is granted.
- R2: `reg_addr[3:2]` selects the channel and `reg_addr[1:0]` selects the register: 0 source, 1 destination, 2 count, 3 control. Each register reads back on `reg_rdata`, and all of them read zero after reset. Control bits are: [1:0] destination mode, [3:2] source mode, [4] 32-bit element (0 = 16-bit), [5] wait for trigger, [6] interrupt enable, [7] sticky error, [15] enable.
- R3: Channels 0 to 2 take the element count from count bits [13:0], and a value of zero means 16384 elements. Channel 3 takes count bits [15:0], and a value of zero means 65536 elements.
- R4: The address mode codes are 00 increment, 01 decrement, 10 fixed and 11 increment. The destination is loaded from its register at the start of every run. The step is 2 bytes for 16-bit elements and 4 bytes for 32-bit elements. The data written equals the data read from the current source address.
- R5: At the start of a run, the low source and destination address bits are cleared to the element size: bit 0 for 16-bit elements, bits 1:0 for 32-bit elements. Every bus address is aligned.
- R6: With control bit 5 clear, writing the enable bit starts the channel. With bit 5 set, the channel stays idle until its `trig` bit rises while it is enabled.
- R7: Address bits [31:28] give the region: below 8 is internal, 8 to 13 is cartridge, 14 and 15 are save RAM. Channel 0 may read and write only internal memory. Channels 1 and 2 may also read the cartridge region. Channel 3 may also read and write the cartridge region. No channel reaches save RAM. A forbidden element makes no bus access, still uses up one count, and sets control bit 7.
- R8: When the last element is done, the channel clears its enable bit. If interrupt enable is set, the channel's `irq` bit pulses for exactly one cycle.
- R9: `cpu_stall` is high from the first cycle of a run until the run ends. Bus requests occur only while it is high, and `irq` is never high while it is high.
- R10: Each element is a read followed by a write. A request holds its address and direction steady until `mem_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel and register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| trig | input | 4 | Per-channel start events |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit element, 0 = 16-bit |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Access accepted this cycle |
| cpu_stall | output | 1 | Processor hold while a run is active |
| irq | output | 4 | Per-channel done pulses |

## Verification
The alignment and hold properties assume that software never rewrites the registers of the channel that is running. A mid-run change to the element size or mode could legally move the bus address. The stimulus writes only channels that are idle, or it waits for trigger-mode channels before firing them. The memory side may insert any number of wait cycles, and the bench drives `mem_ready` randomly except in the long count runs. Random transfers stay within the internal region, while directed cases cover region crossings, simultaneous triggers and zero or oversized counts.

// File: rtl/quad_dma.sv
module quad_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [3:0]    trig,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          cpu_stall,
  output logic [3:0]    irq
);
  localparam int NCH = 4;
  localparam int B_WORD = 4, B_TRG = 5, B_IRQ = 6, B_ERR = 7, B_EN = 15;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] src_r [NCH];
  logic [AW-1:0] dst_r [NCH];
  logic [15:0]   cnt_r [NCH];
  logic [15:0]   ctl_r [NCH];
  logic [3:0]    trig_q, armed, irq_pend, pend;
  logic [1:0]    cur_ch, gnt, wch;
  logic [AW-1:0] cur_src, cur_dst;
  logic [16:0]   left, cload;
  logic [15:0]   craw, cctl;
  logic [31:0]   dbuf;
  logic          rd_ok, wr_ok, elem_ok, adv;

  function automatic logic in_int(input logic [AW-1:0] a);
    return a[AW-1 -: 4] < 4'h8;
  endfunction

  function automatic logic in_cart(input logic [AW-1:0] a);
    return a[AW-1 -: 4] >= 4'h8 && a[AW-1 -: 4] <= 4'hD;
  endfunction

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input logic w);
    return w ? {a[AW-1:2], 2'b00} : {a[AW-1:1], 1'b0};
  endfunction

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m, input logic w);
    logic [AW-1:0] d;
    d = w ? AW'(4) : AW'(2);
    case (m)
      2'b01:   return a - d;
      2'b10:   return a;
      default: return a + d;
    endcase
  endfunction

  assign wch  = reg_addr[3:2];
  assign cctl = ctl_r[cur_ch];

  always_comb begin
    for (int i = 0; i < NCH; i++)
      pend[i] = ctl_r[i][B_EN] & (~ctl_r[i][B_TRG] | armed[i]);
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) gnt = 2'(i);
    craw  = (gnt == 2'd3) ? cnt_r[gnt] : {2'b00, cnt_r[gnt][13:0]};
    cload = (craw != 16'd0) ? {1'b0, craw} : ((gnt == 2'd3) ? 17'h10000 : 17'h04000);
  end

  always_comb begin
    case (reg_addr[1:0])
      2'd0:    reg_rdata = 32'(src_r[wch]);
      2'd1:    reg_rdata = 32'(dst_r[wch]);
      2'd2:    reg_rdata = {16'h0, cnt_r[wch]};
      default: reg_rdata = {16'h0, ctl_r[wch]};
    endcase
  end

  assign rd_ok   = in_int(cur_src) | ((cur_ch != 2'd0) & in_cart(cur_src));
  assign wr_ok   = in_int(cur_dst) | ((cur_ch == 2'd3) & in_cart(cur_dst));
  assign elem_ok = rd_ok & wr_ok;
  assign adv     = (st == S_RD & ~elem_ok) | (st == S_WR & mem_ready);

  assign mem_req   = (st == S_RD & elem_ok) | (st == S_WR);
  assign mem_we    = st == S_WR;
  assign mem_addr  = (st == S_WR) ? cur_dst : cur_src;
  assign mem_wdata = dbuf;
  assign mem_word  = cctl[B_WORD];
  assign cpu_stall = st != S_IDLE;
  assign irq       = (st == S_IDLE) ? irq_pend : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_ch   <= '0;
      cur_src  <= '0;
      cur_dst  <= '0;
      left     <= '0;
      dbuf     <= '0;
      trig_q   <= '0;
      armed    <= '0;
      irq_pend <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_r[i] <= '0;
        dst_r[i] <= '0;
        cnt_r[i] <= '0;
        ctl_r[i] <= '0;
      end
    end else begin
      trig_q <= trig;
      for (int i = 0; i < NCH; i++)
        if (trig[i] & ~trig_q[i] & ctl_r[i][B_EN] & ctl_r[i][B_TRG]) armed[i] <= 1'b1;
      if (reg_we) begin
        case (reg_addr[1:0])
          2'd0: src_r[wch] <= reg_wdata[AW-1:0];
          2'd1: dst_r[wch] <= reg_wdata[AW-1:0];
          2'd2: cnt_r[wch] <= reg_wdata[15:0];
          default: begin
            ctl_r[wch] <= reg_wdata[15:0];
            armed[wch] <= 1'b0;
          end
        endcase
      end
      if (st == S_IDLE) irq_pend <= '0;
      case (st)
        S_IDLE: if (|pend) begin
          cur_ch     <= gnt;
          cur_src    <= align(src_r[gnt], ctl_r[gnt][B_WORD]);
          cur_dst    <= align(dst_r[gnt], ctl_r[gnt][B_WORD]);
          left       <= cload;
          armed[gnt] <= 1'b0;
          st         <= S_RD;
        end
        S_RD: if (!elem_ok) ctl_r[cur_ch][B_ERR] <= 1'b1;
              else if (mem_ready) begin
                dbuf <= mem_rdata;
                st   <= S_WR;
              end
        default: ;
      endcase
      if (adv) begin
        cur_src <= step(cur_src, cctl[3:2], cctl[B_WORD]);
        cur_dst <= step(cur_dst, cctl[1:0], cctl[B_WORD]);
        left    <= left - 17'd1;
        if (left == 17'd1) begin
          st <= S_IDLE;
          ctl_r[cur_ch][B_EN] <= 1'b0;
          if (cctl[B_IRQ]) irq_pend[cur_ch] <= 1'b1;
        end else begin
          st <= S_RD;
        end
      end
    end
  end
endmodule

// File: rtl/quad_dma_chk.sv
module quad_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_stall,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_word,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    irq
);
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_word |-> mem_addr[1:0] == 2'b00); // R5
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[0] == 1'b0); // R5
  AST_NO_SAVE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[AW-1 -: 3] != 3'b111); // R7
  AST_BUS_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall); // R9
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |=> irq == 4'b0); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
endmodule

bind quad_dma quad_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall), .mem_req(mem_req),
  .mem_we(mem_we), .mem_word(mem_word), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .irq(irq)
);

// File: tb/test_quad_dma.sv
module test_quad_dma;
  localparam logic [15:0] EN = 16'h8000, TRG = 16'h0020, IEN = 16'h0040, WRD = 16'h0010;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0, trig = '0, irq;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_word, mem_ready = 1'b0, cpu_stall;
  int          n_chk = 0, n_err = 0, n_exp = 0, n_got = 0;
  logic [31:0] ea [0:16499];
  logic [31:0] ed [0:16499];
  logic [3:0]  irq_seen = '0;
  logic        fast = 1'b0;

  always #2 clk = ~clk;

  quad_dma i_quad_dma (.*);

  function automatic logic [31:0] rdfn(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + a[15:0]};
  endfunction
  function automatic logic [31:0] al(input logic [31:0] a, input logic w);
    return w ? {a[31:2], 2'b00} : {a[31:1], 1'b0};
  endfunction
  function automatic logic [31:0] mv(input logic [31:0] a, input logic [1:0] m, input logic w);
    logic [31:0] d;
    d = w ? 32'd4 : 32'd2;
    if (m == 2'b01) return a - d;
    if (m == 2'b10) return a;
    return a + d;
  endfunction
  function automatic logic is_int(input logic [31:0] a);
    return a[31:28] < 4'd8;
  endfunction
  function automatic logic is_cart(input logic [31:0] a);
    return a[31:28] >= 4'd8 && a[31:28] <= 4'd13;
  endfunction

  task automatic chk_eq(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  always @(posedge clk) mem_ready <= fast ? 1'b1 : ($urandom % 3 != 0);
  assign mem_rdata = rdfn(mem_addr);

  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_ready && mem_we) begin
      if (n_got < n_exp) begin
        chk_eq("R10 write address", mem_addr, ea[n_got]);
        chk_eq("R4 write data", mem_wdata, ed[n_got]);
      end else chk_eq("R7 write count", n_got + 1, n_exp);
      n_got++;
    end
    if (mem_req && !cpu_stall) chk_eq("R9 bus without stall", 1, 0);
    if (|irq) begin
      irq_seen |= irq;
      if (cpu_stall) chk_eq("R9 irq while stalled", irq, 0);
    end
  end

  task automatic add_exp(input int ch, input logic [31:0] s0, input logic [31:0] d0,
                         input logic [15:0] c, input logic [15:0] ctl, output logic bad);
    logic [31:0] s, d;
    int n;
    logic w;
    w = ctl[4];
    s = al(s0, w);
    d = al(d0, w);
    n = (ch == 3) ? int'(c) : int'(c[13:0]);
    if (n == 0) n = (ch == 3) ? 65536 : 16384;
    bad = 1'b0;
    for (int k = 0; k < n; k++) begin
      if ((is_int(s) || (ch != 0 && is_cart(s))) && (is_int(d) || (ch == 3 && is_cart(d)))) begin
        if (n_exp < 16500) begin
          ea[n_exp] = d;
          ed[n_exp] = rdfn(s);
        end
        n_exp++;
      end else bad = 1'b1;
      s = mv(s, ctl[3:2], w);
      d = mv(d, ctl[1:0], w);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask
  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] c, input logic [15:0] ctl);
    wr({2'(ch), 2'd0}, s);
    wr({2'(ch), 2'd1}, d);
    wr({2'(ch), 2'd2}, {16'h0, c});
    wr({2'(ch), 2'd3}, {16'h0, ctl | EN});
  endtask
  task automatic wait_done(input int ch, output logic [31:0] v);
    do rd({2'(ch), 2'd3}, v); while (v[15]);
    repeat (4) @(negedge clk);
  endtask
  task automatic fresh;
    n_exp = 0; n_got = 0; irq_seen = '0;
  endtask
  task automatic run(input int ch, input logic [31:0] s, input logic [31:0] d,
                     input logic [15:0] c, input logic [15:0] ctl, input string r);
    logic bad;
    logic [31:0] v;
    fresh();
    add_exp(ch, s, d, c, ctl, bad);
    setup(ch, s, d, c, ctl);
    wait_done(ch, v);
    chk_eq({r, " element count"}, n_got, n_exp);
    chk_eq("R7 error bit", {31'b0, v[7]}, {31'b0, bad});
    chk_eq("R8 enable cleared", {31'b0, v[15]}, 0);
    chk_eq("R8 irq pulse", {28'b0, irq_seen[ch]}, {31'b0, ctl[6]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic bad;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_eq("R9 stall after reset", {31'b0, cpu_stall}, 0);
    chk_eq("R10 no request after reset", {31'b0, mem_req}, 0);
    chk_eq("R8 no irq after reset", {28'b0, irq}, 0);
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      chk_eq("R2 reset readback", v, 0);
    end
    wr(4'b1001, 32'h1234_5678);
    rd(4'b1001, v);
    chk_eq("R2 destination readback", v, 32'h1234_5678);

    run(1, 32'h0200_0000, 32'h0300_0000, 16'd4, WRD | IEN, "R4 increment word");
    run(2, 32'h0200_0101, 32'h0300_0041, 16'd5, 16'h0006, "R5 unaligned half, dec/fixed");
    run(0, 32'h0200_0012, 32'h0300_0016, 16'd3, WRD | 16'h0003, "R4 reload mode first");
    run(0, 32'h0200_0012, 32'h0300_0016, 16'd3, WRD | 16'h0003, "R4 reload mode again");

    // R6 and R1: two trigger-mode channels fired together
    fresh();
    add_exp(1, 32'h0210_0000, 32'h0310_0000, 16'd3, WRD, bad);
    add_exp(2, 32'h0220_0000, 32'h0320_0000, 16'd3, WRD, bad);
    setup(2, 32'h0220_0000, 32'h0320_0000, 16'd3, WRD | TRG);
    setup(1, 32'h0210_0000, 32'h0310_0000, 16'd3, WRD | TRG);
    repeat (10) @(negedge clk);
    chk_eq("R6 idle before trigger", {31'b0, cpu_stall}, 0);
    chk_eq("R6 no writes before trigger", n_got, 0);
    trig = 4'b0110;
    @(negedge clk);
    trig = 4'b0000;
    wait_done(2, v);
    chk_eq("R1 priority order writes", n_got, 6);

    // R9: deferred irq when two channels run back to back
    fresh();
    add_exp(0, 32'h0230_0000, 32'h0330_0000, 16'd5, IEN, bad);
    add_exp(3, 32'h0240_0000, 32'h0340_0000, 16'd20, IEN, bad);
    setup(3, 32'h0240_0000, 32'h0340_0000, 16'd20, IEN | TRG);
    setup(0, 32'h0230_0000, 32'h0330_0000, 16'd5, IEN | TRG);
    trig = 4'b1001;
    @(negedge clk);
    trig = 4'b0000;
    wait_done(3, v);
    chk_eq("R9 both runs complete", n_got, 25);
    chk_eq("R9 deferred irqs delivered", {28'b0, irq_seen}, 32'h9);

    run(0, 32'h0200_0000, 32'h8000_0000, 16'd2, WRD, "R7 ch0 cart write");
    run(0, 32'h8000_0000, 32'h0200_0000, 16'd2, WRD, "R7 ch0 cart read");
    run(1, 32'h8000_0100, 32'h0200_0100, 16'd2, WRD, "R7 ch1 cart read");
    run(2, 32'h0200_0000, 32'h9000_0000, 16'd2, 16'h0000, "R7 ch2 cart write");
    run(3, 32'h0200_0000, 32'hA000_0000, 16'd3, WRD, "R7 ch3 cart write");
    run(3, 32'hE000_0000, 32'h0200_0000, 16'd2, WRD, "R7 ch3 save read");
    run(3, 32'h0200_0000, 32'h7FFF_FFFC, 16'd3, WRD, "R7 ch3 crossing into cart");

    run(1, 32'h0200_0000, 32'h0300_0000, 16'h4003, WRD, "R3 ch1 14-bit mask");
    fast = 1'b1;
    run(0, 32'h0200_0000, 32'h0300_0000, 16'h0000, 16'h0000, "R3 ch0 zero count");
    chk_eq("R3 ch0 zero count is 16384", n_got, 16384);
    run(3, 32'h0200_0000, 32'h0300_0000, 16'h4002, WRD, "R3 ch3 16-bit count");
    chk_eq("R3 ch3 count 0x4002", n_got, 16386);
    fast = 1'b0;

    for (int it = 0; it < 30; it++) begin
      int ch;
      logic [15:0] ctl;
      ch  = int'($urandom % 4);
      ctl = 16'($urandom % 128) & 16'h005F;
      run(ch, 32'h0200_0000 + ($urandom % 4096), 32'h0300_0000 + ($urandom % 4096),
          16'(1 + $urandom % 6), ctl, "R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule